// File: doc/BRIEF.md
# Dual-Channel Double-Latched Converter Input Stage

This block is the digital front end of a two-channel, 12-bit current-steering converter. Each channel has its own parallel data port, its own write strobe and its own update strobe. A word passes through three registers. The write strobe's rising edge captures the port into an entry register. Its falling edge moves that word into a staging register. The next rising edge of the channel's update strobe commits the staged word to the output register. The outputs of each channel are the committed code and its complement, which are the values that would steer the true and complementary current outputs. The strobes are sampled by a faster system clock, and the block detects their edges from those samples.

Each channel runs a two-state ordering machine. `ORD_WAIT_CLK` waits for an update edge. On an update rise without a write rise, the transition *clock_arrives* leads to `ORD_CLK_SEEN`. In that state a write rise takes the transition *write_consumes* back to `ORD_WAIT_CLK`. An update rise and a write rise in the same sample are legal in either state and leave the machine in `ORD_WAIT_CLK`; this transition is called *tied_pair*. A write rise seen in `ORD_WAIT_CLK` with no update rise is the transition *write_early*. It stays in `ORD_WAIT_CLK` and sets that channel's sticky ordering-error flag. A shared power machine has two states, `PWR_ON` and `PWR_OFF`. It takes *sleep* on a high power-down input and *wake* on a low one. In `PWR_OFF` both codes of both channels read zero and all strobe edges are ignored. The registers keep their contents, so operation resumes with the last committed word.

Top module: `dual_dac_front`

## Requirements
- R1: After reset every register of both channels holds zero: the true code reads 0, the complementary code reads 4095, both error flags are low and `pd_status` is low.
- R2: A write strobe sampled high after being sampled low loads the channel's data port into the entry register. Data changes at any other sample do not reach the output.
- R3: A write strobe sampled low after being sampled high copies the entry register into the staging register.
- R4: The committed code changes only at a sample where the update strobe is seen rising, and then it takes the staging value held before that sample. It is visible right after that system clock edge.
- R5: With write and update tied together, each word appears at the output on the strobe rise that follows the strobe fall which staged it, one strobe period after its capture.
- R6: Data is unsigned, with bit 11 as the MSB. The true code equals the committed word and the complementary code equals 4095 minus it, so all-ones gives 4095/0 and all-zeros gives 0/4095.
- R7: A write rise is legal if an update rise occurs in the same sample, or earlier in the current update cycle. A write rise with neither sets that channel's error flag, and the flag then stays set.
- R8: `err_clr` high at a clock edge clears both error flags. A violation in that same sample wins, and its flag stays set.
- R9: `pd_status` shows `pwr_down` one clock later. While it is high, all four code outputs read zero.
- R10: While `pd_status` is high, strobe edges neither move any register nor set an error flag. After wake, the outputs show the last word committed before sleep.
- R11: The two channels are independent: strobes and data on one channel never change the other channel's codes or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | 12 | Channel A data word |
| a_wr | input | 1 | Channel A write strobe |
| a_upd | input | 1 | Channel A update strobe |
| b_data | input | 12 | Channel B data word |
| b_wr | input | 1 | Channel B write strobe |
| b_upd | input | 1 | Channel B update strobe |
| pwr_down | input | 1 | Power-down request, high to sleep |
| err_clr | input | 1 | Clears both ordering-error flags |
| a_code_p | output | 12 | Channel A true code |
| a_code_n | output | 12 | Channel A complementary code |
| b_code_p | output | 12 | Channel B true code |
| b_code_n | output | 12 | Channel B complementary code |
| a_order_err | output | 1 | Channel A sticky ordering error |
| b_order_err | output | 1 | Channel B sticky ordering error |
| pd_status | output | 1 | Power-down state |

## Verification
The tied-strobe case is the main target. Update and write rise in the same sample, so a design that let the commit see the newly captured word, instead of the previously staged one, would show each word one strobe period early. A design that flagged coincident edges would raise false ordering errors. Write-only pulses check that an early write sets the sticky flag. A clear in the same sample as a violation checks that the set wins. Pulses during power-down check that sleep freezes the pipeline rather than letting it drift, and that no flag is raised. Random independent traffic on both channels, in tied and separate timing, catches any cross-channel leak or any lost hand-off when an update rise and a write fall land in the same sample.

// File: rtl/dacf_pkg.sv
package dacf_pkg;

    typedef enum logic [0:0] {
        ORD_WAIT_CLK = 1'b0,
        ORD_CLK_SEEN = 1'b1
    } ord_state_e;

    typedef enum logic [0:0] {
        PWR_ON  = 1'b0,
        PWR_OFF = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/dacf_edge.sv
module dacf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/dacf_order_fsm.sv
module dacf_order_fsm
    import dacf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic upd_rise,
    input  logic wr_rise,
    input  logic clr,
    output logic err
);
    ord_state_e state, state_nx;
    logic       violation;

    always_comb begin
        state_nx  = state;
        violation = 1'b0;
        if (enable) begin
            unique case (state)
                ORD_WAIT_CLK: begin
                    if (upd_rise && wr_rise)  state_nx = ORD_WAIT_CLK;   // tied_pair
                    else if (upd_rise)        state_nx = ORD_CLK_SEEN;   // clock_arrives
                    else if (wr_rise) begin
                        state_nx  = ORD_WAIT_CLK;                        // write_early
                        violation = 1'b1;
                    end
                end
                ORD_CLK_SEEN: begin
                    if (upd_rise && wr_rise)  state_nx = ORD_WAIT_CLK;   // tied_pair
                    else if (wr_rise)         state_nx = ORD_WAIT_CLK;   // write_consumes
                    else                      state_nx = ORD_CLK_SEEN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ORD_WAIT_CLK;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err <= 1'b0;
        else        err <= violation | (err & ~clr);
    end
endmodule

// File: rtl/dacf_power_ctl.sv
module dacf_power_ctl
    import dacf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic pd_active
);
    pwr_state_e state, state_nx;

    always_comb begin
        unique case (state)
            PWR_ON:  state_nx = pwr_down ? PWR_OFF : PWR_ON;   // sleep
            PWR_OFF: state_nx = pwr_down ? PWR_OFF : PWR_ON;   // wake
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PWR_ON;
        else        state <= state_nx;
    end

    always_comb pd_active = (state == PWR_OFF);
endmodule

// File: rtl/dacf_channel.sv
module dacf_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_active,
    input  logic              err_clr,
    input  logic [CODE_W-1:0] data,
    input  logic              wr,
    input  logic              upd,
    output logic [CODE_W-1:0] code_p,
    output logic [CODE_W-1:0] code_n,
    output logic              order_err
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    logic              wr_rise, wr_fall, upd_rise, upd_fall;
    logic              live;
    logic [CODE_W-1:0] entry_q, stage_q, commit_q;

    assign live = ~pd_active;

    dacf_edge u_wr_edge (
        .clk (clk), .rst_n (rst_n), .sig (wr),
        .rise(wr_rise), .fall(wr_fall)
    );

    dacf_edge u_upd_edge (
        .clk (clk), .rst_n (rst_n), .sig (upd),
        .rise(upd_rise), .fall(upd_fall)
    );

    dacf_order_fsm u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (live),
        .upd_rise(upd_rise),
        .wr_rise (wr_rise),
        .clr     (err_clr),
        .err     (order_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q  <= '0;
            stage_q  <= '0;
            commit_q <= '0;
        end else if (live) begin
            if (wr_rise)  entry_q  <= data;
            if (wr_fall)  stage_q  <= entry_q;
            if (upd_rise) commit_q <= stage_q;
        end
    end

    always_comb begin
        if (pd_active) begin
            code_p = '0;
            code_n = '0;
        end else begin
            code_p = commit_q;
            code_n = FULL - commit_q;
        end
    end

    logic unused_fall;
    assign unused_fall = upd_fall;
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] a_data,
    input  logic              a_wr,
    input  logic              a_upd,
    input  logic [CODE_W-1:0] b_data,
    input  logic              b_wr,
    input  logic              b_upd,
    input  logic              pwr_down,
    input  logic              err_clr,
    output logic [CODE_W-1:0] a_code_p,
    output logic [CODE_W-1:0] a_code_n,
    output logic [CODE_W-1:0] b_code_p,
    output logic [CODE_W-1:0] b_code_n,
    output logic              a_order_err,
    output logic              b_order_err,
    output logic              pd_status
);
    localparam int NCH = 2;

    logic [NCH-1:0][CODE_W-1:0] data_arr, p_arr, n_arr;
    logic [NCH-1:0]             wr_arr, upd_arr, err_arr;
    logic                       pd_active;

    assign data_arr = {b_data, a_data};
    assign wr_arr   = {b_wr, a_wr};
    assign upd_arr  = {b_upd, a_upd};

    dacf_power_ctl u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .pd_active(pd_active)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dacf_channel #(.CODE_W(CODE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pd_active(pd_active),
            .err_clr  (err_clr),
            .data     (data_arr[c]),
            .wr       (wr_arr[c]),
            .upd      (upd_arr[c]),
            .code_p   (p_arr[c]),
            .code_n   (n_arr[c]),
            .order_err(err_arr[c])
        );
    end

    assign a_code_p    = p_arr[0];
    assign a_code_n    = n_arr[0];
    assign b_code_p    = p_arr[1];
    assign b_code_n    = n_arr[1];
    assign a_order_err = err_arr[0];
    assign b_order_err = err_arr[1];
    assign pd_status   = pd_active;
endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_wr,
    input logic              a_upd,
    input logic              b_wr,
    input logic              b_upd,
    input logic              pwr_down,
    input logic              err_clr,
    input logic [CODE_W-1:0] a_code_p,
    input logic [CODE_W-1:0] a_code_n,
    input logic [CODE_W-1:0] b_code_p,
    input logic [CODE_W-1:0] b_code_n,
    input logic              a_order_err,
    input logic              b_order_err,
    input logic              pd_status
);
    localparam logic [CODE_W:0] SUM_FULL = {1'b0, {CODE_W{1'b1}}};

    logic a_wr_s, a_upd_s, b_wr_s, b_upd_s;
    logic a_wr_up, a_upd_up, b_wr_up, b_upd_up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) {a_wr_s, a_upd_s, b_wr_s, b_upd_s} <= '0;
        else        {a_wr_s, a_upd_s, b_wr_s, b_upd_s} <= {a_wr, a_upd, b_wr, b_upd};
    end

    assign a_wr_up  = a_wr  & ~a_wr_s;
    assign a_upd_up = a_upd & ~a_upd_s;
    assign b_wr_up  = b_wr  & ~b_wr_s;
    assign b_upd_up = b_upd & ~b_upd_s;

    assert_pd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_status |-> (a_code_p == '0 && a_code_n == '0 && b_code_p == '0 && b_code_n == '0));

    assert_pd_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pd_status == $past(pwr_down)));

    assert_compl_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_status |-> ({1'b0, a_code_p} + {1'b0, a_code_n} == SUM_FULL));

    assert_compl_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_status |-> ({1'b0, b_code_p} + {1'b0, b_code_n} == SUM_FULL));

    assert_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_upd_up && !pd_status) |=> (pd_status || $stable(a_code_p)));

    assert_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_upd_up && !pd_status) |=> (pd_status || $stable(b_code_p)));

    assert_err_cause_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_order_err && !a_wr_up) |=> !a_order_err);

    assert_err_cause_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_order_err && !b_wr_up) |=> !b_order_err);

    assert_err_sticky_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_order_err && !err_clr) |=> a_order_err);

    assert_err_sticky_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_order_err && !err_clr) |=> b_order_err);

    assert_pd_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_status && !a_order_err) |=> !a_order_err);
endmodule

bind dual_dac_front dual_dac_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_wr       (a_wr),
    .a_upd      (a_upd),
    .b_wr       (b_wr),
    .b_upd      (b_upd),
    .pwr_down   (pwr_down),
    .err_clr    (err_clr),
    .a_code_p   (a_code_p),
    .a_code_n   (a_code_n),
    .b_code_p   (b_code_p),
    .b_code_n   (b_code_n),
    .a_order_err(a_order_err),
    .b_order_err(b_order_err),
    .pd_status  (pd_status)
);

// File: tb/dual_dac_front_test.sv
`timescale 1ns/1ps
module dual_dac_front_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [11:0] drv_dat [2];
    logic        drv_wr  [2];
    logic        drv_upd [2];
    logic        drv_pd, drv_clr;

    logic [11:0] a_code_p, a_code_n, b_code_p, b_code_n;
    logic        a_order_err, b_order_err, pd_status;

    dual_dac_front uut (
        .clk(clk), .rst_n(rst_n),
        .a_data(drv_dat[0]), .a_wr(drv_wr[0]), .a_upd(drv_upd[0]),
        .b_data(drv_dat[1]), .b_wr(drv_wr[1]), .b_upd(drv_upd[1]),
        .pwr_down(drv_pd), .err_clr(drv_clr),
        .a_code_p(a_code_p), .a_code_n(a_code_n),
        .b_code_p(b_code_p), .b_code_n(b_code_n),
        .a_order_err(a_order_err), .b_order_err(b_order_err),
        .pd_status(pd_status)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model of the pipeline
    logic [11:0] m_entry [2];
    logic [11:0] m_stage [2];
    logic [11:0] m_commit[2];
    logic        m_pw [2];
    logic        m_pu [2];
    logic        m_seen[2];
    logic        m_err [2];
    logic        m_pd;

    function automatic logic [11:0] exp_p(input logic [11:0] w, input logic pd);
        return pd ? 12'd0 : w;
    endfunction

    function automatic logic [11:0] exp_n(input logic [11:0] w, input logic pd);
        return pd ? 12'd0 : 12'(4095 - int'(w));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_entry[c] = '0; m_stage[c] = '0; m_commit[c] = '0;
            m_pw[c] = 0; m_pu[c] = 0; m_seen[c] = 0; m_err[c] = 0;
        end
        m_pd = 0;
    endtask

    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            logic rw, fw, ru, vio;
            rw  = drv_wr[c] & ~m_pw[c];
            fw  = ~drv_wr[c] & m_pw[c];
            ru  = drv_upd[c] & ~m_pu[c];
            vio = 0;
            m_pw[c] = drv_wr[c];
            m_pu[c] = drv_upd[c];
            if (!m_pd) begin
                if (ru) m_commit[c] = m_stage[c];
                if (fw) m_stage[c]  = m_entry[c];
                if (rw) m_entry[c]  = drv_dat[c];
                if (ru && rw)      m_seen[c] = 0;
                else if (ru)       m_seen[c] = 1;
                else if (rw) begin
                    if (!m_seen[c]) vio = 1;
                    m_seen[c] = 0;
                end
            end
            m_err[c] = vio | (m_err[c] & ~drv_clr);
        end
        m_pd = drv_pd;
    endtask

    task automatic compare_all();
        chk("R4 R6 R9 R11 a true code", a_code_p, exp_p(m_commit[0], m_pd));
        chk("R6 R9 a compl code",       a_code_n, exp_n(m_commit[0], m_pd));
        chk("R4 R6 R9 R11 b true code", b_code_p, exp_p(m_commit[1], m_pd));
        chk("R6 R9 b compl code",       b_code_n, exp_n(m_commit[1], m_pd));
        chk("R7 R8 a order err",        a_order_err, m_err[0]);
        chk("R7 R8 b order err",        b_order_err, m_err[1]);
        chk("R9 pd status",             pd_status, m_pd);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        compare_all();
    endtask

    task automatic idle_all();
        for (int c = 0; c < 2; c++) begin
            drv_wr[c] = 0; drv_upd[c] = 0;
        end
        drv_clr = 0;
    endtask

    // one tied strobe period on channel c: high one tick, low one tick
    task automatic tied_pulse(input int c, input logic [11:0] w);
        drv_dat[c] = w; drv_wr[c] = 1; drv_upd[c] = 1;
        tick();
        drv_wr[c] = 0; drv_upd[c] = 0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] held_a;
        int mode [2];
        void'($urandom(32'h5EED_0C0D));
        for (int c = 0; c < 2; c++) drv_dat[c] = '0;
        drv_pd = 0;
        idle_all();
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1;
        #(CLK_PERIOD/2);
        // R1: reset state
        chk("R1 reset a true", a_code_p, 0);
        chk("R1 reset a compl", a_code_n, 4095);
        chk("R1 reset b compl", b_code_n, 4095);
        chk("R1 reset err", {a_order_err, b_order_err}, 0);
        chk("R1 reset pd", pd_status, 0);
        tick();

        // R5 R6: tied strobes, all-ones then all-zeros
        tied_pulse(0, 12'hFFF);
        chk("R5 word not yet committed", a_code_p, 0);
        tied_pulse(0, 12'h000);
        chk("R5 R6 all ones true", a_code_p, 4095);
        chk("R5 R6 all ones compl", a_code_n, 0);
        chk("R11 b untouched", b_code_p, 0);
        tied_pulse(0, 12'h800);
        chk("R5 R6 all zeros true", a_code_p, 0);
        chk("R6 all zeros compl", a_code_n, 4095);
        chk("R7 tied no err", a_order_err, 0);

        // R2: data changes while write held high do not matter
        drv_dat[0] = 12'h123; drv_wr[0] = 1; drv_upd[0] = 1; tick();
        drv_dat[0] = 12'hABC; tick();
        drv_wr[0] = 0; drv_upd[0] = 0; tick();
        drv_upd[0] = 1; tick();
        chk("R2 R3 captured at rise", a_code_p, 12'h123);

        // R7: separate timing, clock before write is legal
        drv_upd[0] = 0; tick();
        drv_upd[1] = 1; tick();
        drv_dat[1] = 12'h5A5; tick();
        drv_wr[1] = 1; tick();
        chk("R7 late write legal", b_order_err, 0);
        drv_wr[1] = 0; drv_upd[1] = 0; tick();
        // write rise with no clock edge in the cycle
        drv_wr[1] = 1; tick();
        chk("R7 early write flagged", b_order_err, 1);
        drv_wr[1] = 0; tick(); tick();
        chk("R7 flag sticky", b_order_err, 1);
        chk("R11 a flag independent", a_order_err, 0);
        // R8: clear together with a new violation: set wins
        drv_wr[1] = 1; drv_clr = 1; tick();
        chk("R8 set wins over clear", b_order_err, 1);
        drv_wr[1] = 0; tick();
        chk("R8 clear", b_order_err, 0);
        drv_clr = 0; tick();

        // R9 R10: power down freezes pipeline, ignores strobes
        held_a = a_code_p;
        drv_pd = 1; tick();
        chk("R9 pd outputs zero", a_code_p, 0);
        chk("R9 pd status high", pd_status, 1);
        tied_pulse(0, 12'h777);
        tied_pulse(0, 12'h321);
        drv_dat[1] = 12'h0F0; drv_wr[1] = 1; tick();
        drv_wr[1] = 0; tick();
        chk("R10 no err in pd", b_order_err, 0);
        drv_pd = 0; tick();
        chk("R10 resume last word", a_code_p, held_a);
        tick();

        // random phase: tied or separate timing per channel
        mode[0] = 0; mode[1] = 1;
        for (int k = 0; k < 3000; k++) begin
            if (k % 50 == 0) begin
                mode[0] = int'($urandom % 2);
                mode[1] = int'($urandom % 2);
            end
            for (int c = 0; c < 2; c++) begin
                if ($urandom % 3 == 0) drv_wr[c] = ~drv_wr[c];
                if (mode[c] == 0) drv_upd[c] = drv_wr[c];
                else if ($urandom % 3 == 0) drv_upd[c] = ~drv_upd[c];
                drv_dat[c] = 12'($urandom);
            end
            drv_clr = ($urandom % 32 == 0);
            if ($urandom % 64 == 0) drv_pd = ~drv_pd;
            tick();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule